// File: doc/BRIEF.md
# CAN transceiver mode select and wake-up filter

This block is the digital core that drives the receive output of a high-speed CAN transceiver. A standby control input picks one of two modes. In normal mode the receive output mirrors the sampled bus state, so the protocol controller sees dominant bits as a low level. In standby mode the receive output stays high unless a low-power bus-activity comparator reports a dominant level that lasts long enough to count as a wake-up request.

The wake-up indication is not latched. A glitch or a short dominant pulse is filtered out by a minimum-duration counter. Once a wake-up is reported, the output stays low while the bus remains dominant. It returns high only after the bus has been recessive for a programmable release delay. A wake-up cannot be reported while the main supply is flagged as absent. Any change on the standby input discards a partial count and any pending indication. Both time constants are parameters counted in clock cycles, and the bus, standby and supply flags are taken as already synchronous to the clock.

Top module: `can_wake_rx`

## Requirements
- R1: While reset is asserted and right after it is released with the standby input high (1 = standby), the block is in standby mode and rxd_o is high.
- R2: With the standby input low (0 = normal), rxd_o equals the inverse of bus_dom_i (1 = dominant) as sampled at the previous clock edge. It is low for dominant and high for recessive, and no filter or release delay applies.
- R3: In standby mode rxd_o is high whenever no valid wake-up request is pending.
- R4: In standby mode with the supply present, rxd_o goes low in the cycle after the (WAKE_CYC+1)-th consecutive dominant sample, and stays low while the bus stays dominant.
- R5: A run of WAKE_CYC or fewer consecutive dominant samples leaves rxd_o high, and a single recessive sample restarts the dominant count from zero.
- R6: After a wake-up, rxd_o returns high in the cycle after the REL_CYC-th consecutive recessive sample. A dominant sample during the release restarts the release count, and rxd_o stays low meanwhile.
- R7: While supply_ok_i is low (0 = supply absent), no wake-up is reported, any pending indication is cleared at the next edge, and the dominant count restarts.
- R8: A change on the standby input clears the dominant count and any pending wake-up indication. After entering standby, WAKE_CYC+1 fresh dominant samples are needed for a wake-up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stby_i | input | 1 | Mode select: 1 = standby, 0 = normal |
| bus_dom_i | input | 1 | Sampled bus state: 1 = dominant, 0 = recessive |
| supply_ok_i | input | 1 | Main supply present flag: 1 = present |
| rxd_o | output | 1 | Receive output to the protocol controller, low = dominant or wake-up |

## Verification
On every cycle the assertions check several behaviours. In normal mode the output must mirror the previous bus sample, and it must stay high in standby while the supply is absent. In standby, no falling edge of the output may appear without a run of more than WAKE_CYC dominant samples behind it, and no rising edge may appear before REL_CYC recessive samples. These one-sided bounds cannot show that a wake-up or release happens in exactly the required cycle. They also cannot show that a mode change really discards a partial count. The directed scenarios establish those points: exact-threshold runs, pulses one sample short, a release interrupted by a dominant sample, and supply loss and mode toggles in the middle of a count.

// File: rtl/can_wake_pkg.sv
package can_wake_pkg;
  typedef enum logic {
    MODE_NORMAL  = 1'b0,
    MODE_STANDBY = 1'b1
  } mode_e;
endpackage

// File: rtl/cwk_mode_sel.sv
module cwk_mode_sel
  import can_wake_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  stby_i,
  output mode_e mode_o,
  output logic  chg_o
);
  mode_e mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_STANDBY;
    else         mode_q <= stby_i ? MODE_STANDBY : MODE_NORMAL;
  end

  assign mode_o = mode_q;
  // request differs from current mode: flush filter state this edge
  assign chg_o  = (stby_i != logic'(mode_q));
endmodule

// File: rtl/cwk_wake_filter.sv
module cwk_wake_filter #(
  parameter int unsigned WAKE_CYC = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic dom_i,
  output logic det_o
);
  localparam int unsigned CW = $clog2(WAKE_CYC + 1);
  localparam logic [CW-1:0] CNT_TOP = CW'(WAKE_CYC);

  logic [CW-1:0] cnt_q;
  logic          at_top;

  assign at_top = (cnt_q == CNT_TOP);
  // valid once a sample arrives beyond WAKE_CYC consecutive dominant ones
  assign det_o  = arm_i && dom_i && at_top;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!arm_i || !dom_i)  cnt_q <= '0;
    else if (!at_top)           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cwk_wake_hold.sv
module cwk_wake_hold #(
  parameter int unsigned REL_CYC = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic det_i,
  input  logic dom_i,
  output logic hold_o
);
  localparam int unsigned RW = $clog2(REL_CYC + 1);
  localparam logic [RW-1:0] REL_LAST = RW'(REL_CYC - 1);

  logic          hold_q;
  logic [RW-1:0] rel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= 1'b0;
      rel_q  <= '0;
    end else if (!arm_i) begin
      hold_q <= 1'b0;
      rel_q  <= '0;
    end else if (det_i) begin
      hold_q <= 1'b1;
      rel_q  <= '0;
    end else if (hold_q) begin
      if (dom_i) begin
        rel_q <= '0;
      end else if (rel_q == REL_LAST) begin
        hold_q <= 1'b0;
        rel_q  <= '0;
      end else begin
        rel_q <= rel_q + 1'b1;
      end
    end
  end

  assign hold_o = hold_q;
endmodule

// File: rtl/can_wake_rx.sv
module can_wake_rx
  import can_wake_pkg::*;
#(
  parameter int unsigned WAKE_CYC = 100,
  parameter int unsigned REL_CYC  = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stby_i,
  input  logic bus_dom_i,
  input  logic supply_ok_i,
  output logic rxd_o
);
  mode_e mode;
  logic  chg;
  logic  arm;
  logic  det;
  logic  hold;
  logic  dom_q;

  cwk_mode_sel u_mode (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stby_i (stby_i),
    .mode_o (mode),
    .chg_o  (chg)
  );

  assign arm = (mode == MODE_STANDBY) && !chg && supply_ok_i;

  cwk_wake_filter #(.WAKE_CYC(WAKE_CYC)) u_filt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .arm_i  (arm),
    .dom_i  (bus_dom_i),
    .det_o  (det)
  );

  cwk_wake_hold #(.REL_CYC(REL_CYC)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .arm_i  (arm),
    .det_i  (det),
    .dom_i  (bus_dom_i),
    .hold_o (hold)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dom_q <= 1'b0;
    else         dom_q <= bus_dom_i;
  end

  assign rxd_o = (mode == MODE_NORMAL) ? !dom_q : !hold;
endmodule

// File: rtl/cwk_checker.sv
module cwk_checker #(
  parameter int unsigned WAKE_CYC = 100,
  parameter int unsigned REL_CYC  = 50
) (
  input logic clk_i,
  input logic rst_ni,
  input logic stby_i,
  input logic bus_dom_i,
  input logic supply_ok_i,
  input logic rxd_o
);
  localparam int unsigned RUNW = $clog2(WAKE_CYC + 2);
  localparam int unsigned RECW = $clog2(REL_CYC + 1);
  localparam logic [RUNW-1:0] RUN_MAX = RUNW'(WAKE_CYC + 1);
  localparam logic [RECW-1:0] REC_MAX = RECW'(REL_CYC);

  logic            seen_q, seen2_q;
  logic [RUNW-1:0] run_q;
  logic [RECW-1:0] rec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q  <= 1'b0;
      seen2_q <= 1'b0;
      run_q   <= '0;
      rec_q   <= '0;
    end else begin
      seen_q  <= 1'b1;
      seen2_q <= seen_q;
      if (!(bus_dom_i && supply_ok_i && stby_i)) run_q <= '0;
      else if (run_q != RUN_MAX)                 run_q <= run_q + 1'b1;
      if (bus_dom_i)                             rec_q <= '0;
      else if (rec_q != REC_MAX)                 rec_q <= rec_q + 1'b1;
    end
  end

  AST_NORMAL_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && !$past(stby_i) |-> rxd_o == !$past(bus_dom_i)); // R2

  AST_NO_SUPPLY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(stby_i) && !$past(supply_ok_i) |-> rxd_o); // R7

  AST_WAKE_FILTERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(stby_i) && $fell(rxd_o) |-> run_q > RUNW'(WAKE_CYC)); // R5

  AST_RELEASE_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen2_q && $past(stby_i) && $past(stby_i, 2) && $past(supply_ok_i) && $rose(rxd_o)
    |-> rec_q >= REC_MAX); // R6
endmodule

bind can_wake_rx cwk_checker #(.WAKE_CYC(WAKE_CYC), .REL_CYC(REL_CYC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .stby_i      (stby_i),
  .bus_dom_i   (bus_dom_i),
  .supply_ok_i (supply_ok_i),
  .rxd_o       (rxd_o)
);

// File: tb/can_wake_rx_test.sv
`timescale 1ns/1ps
module can_wake_rx_test;
  localparam int W = 4;
  localparam int REL = 3;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic stby_i = 1'b1;
  logic bus_dom_i = 1'b0;
  logic supply_ok_i = 1'b1;
  logic rxd_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  can_wake_rx #(.WAKE_CYC(W), .REL_CYC(REL)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .stby_i(stby_i),
    .bus_dom_i(bus_dom_i), .supply_ok_i(supply_ok_i), .rxd_o(rxd_o)
  );

  task automatic tick(int n = 1);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic chk(string req, logic exp, string what);
    n_chk++;
    if (rxd_o !== exp) begin
      n_fail++;
      $display("FAIL %s %s: rxd actual=%b expected=%b", req, what, rxd_o, exp);
    end
  endtask

  task automatic t_reset();
    rst_ni = 1'b0; stby_i = 1'b1; bus_dom_i = 1'b1; supply_ok_i = 1'b1;
    tick(3);
    chk("R1", 1'b1, "during reset");
    bus_dom_i = 1'b0;
    rst_ni = 1'b1;
    tick();
    chk("R1", 1'b1, "after reset");
    tick(2);
    chk("R3", 1'b1, "idle standby");
  endtask

  task automatic t_normal();
    logic [7:0] pat;
    pat = 8'b1011_0010;
    stby_i = 1'b0;
    for (int i = 0; i < 8; i++) begin
      bus_dom_i = pat[i];
      tick();
      chk("R2", !pat[i], "normal follow");
    end
    bus_dom_i = 1'b1;
    tick(W + 3);
    chk("R2", 1'b0, "long dominant normal");
    bus_dom_i = 1'b0;
    tick();
    chk("R2", 1'b1, "immediate release normal");
  endtask

  task automatic t_short_pulses();
    stby_i = 1'b1; bus_dom_i = 1'b0;
    tick(2);
    for (int len = 1; len <= W; len++) begin
      bus_dom_i = 1'b1;
      for (int k = 0; k < len; k++) begin
        tick();
        chk("R5", 1'b1, "short pulse");
      end
      bus_dom_i = 1'b0;
      tick();
      chk("R3", 1'b1, "after short pulse");
    end
    bus_dom_i = 1'b1; tick(W);
    bus_dom_i = 1'b0; tick();
    bus_dom_i = 1'b1; tick(W);
    chk("R5", 1'b1, "count restarted by recessive");
    bus_dom_i = 1'b0; tick();
  endtask

  task automatic wake_up();
    bus_dom_i = 1'b1;
    for (int k = 1; k <= W + 1; k++) begin
      tick();
      chk("R4", (k == W + 1) ? 1'b0 : 1'b1, "wake threshold");
    end
  endtask

  task automatic t_wake_release();
    wake_up();
    tick(3);
    chk("R4", 1'b0, "held while dominant");
    bus_dom_i = 1'b0;
    for (int k = 1; k <= REL; k++) begin
      tick();
      chk("R6", (k == REL) ? 1'b1 : 1'b0, "release delay");
    end
  endtask

  task automatic t_release_restart();
    wake_up();
    bus_dom_i = 1'b0; tick(REL - 1);
    chk("R6", 1'b0, "partial release");
    bus_dom_i = 1'b1; tick();
    chk("R6", 1'b0, "dominant in release");
    bus_dom_i = 1'b0; tick(REL - 1);
    chk("R6", 1'b0, "release restarted");
    tick();
    chk("R6", 1'b1, "release done");
  endtask

  task automatic t_supply();
    supply_ok_i = 1'b0; bus_dom_i = 1'b1;
    tick(W + 3);
    chk("R7", 1'b1, "no wake without supply");
    supply_ok_i = 1'b1;
    tick(W);
    chk("R7", 1'b1, "count restarted on supply return");
    tick();
    chk("R4", 1'b0, "wake after supply return");
    supply_ok_i = 1'b0;
    tick();
    chk("R7", 1'b1, "pending cleared on supply loss");
    supply_ok_i = 1'b1; bus_dom_i = 1'b0;
    tick();
  endtask

  task automatic t_mode_change();
    bus_dom_i = 1'b1;
    tick(W);
    chk("R5", 1'b1, "partial count");
    stby_i = 1'b0; tick();
    chk("R2", 1'b0, "normal shows dominant");
    stby_i = 1'b1; tick();
    chk("R8", 1'b1, "back to standby");
    tick(W);
    chk("R8", 1'b1, "count cleared by mode change");
    tick();
    chk("R8", 1'b0, "fresh full run wakes");
    bus_dom_i = 1'b0;
    stby_i = 1'b0; tick();
    chk("R2", 1'b1, "normal recessive");
    stby_i = 1'b1; tick();
    chk("R8", 1'b1, "pending cleared by mode change");
  endtask

  initial begin
    t_reset();
    t_normal();
    t_short_pulses();
    t_wake_release();
    t_release_restart();
    t_supply();
    t_mode_change();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog: actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule